// File: doc/BRIEF.md
# Interrupt Dispatch and Status-Word Exchange Controller

This block decides which pending interruption a processor core takes next and carries out the status-word exchange for it. It looks at five sources: a program exception request, a supervisor-call request, a queued external interruption, a clock-comparator event and a CPU-timer event. When it is idle, it grants the highest-ranked eligible source. It then saves the interruption information and the old status word into that class's save area, reads the class's new status word from the same area, and makes that word the current one.

The save areas lie at fixed offsets from a prefix base address. The external class uses offset 0x40, supervisor call uses 0x80 and program uses 0xC0. Each area holds five 64-bit words at byte offsets +0 to +32, one access per cycle, with the most significant byte at the lowest address. The core supplies the live condition code, the instruction length, the CPU number and the request lines. It gets back the current status word, a halt indication, a dead-stop indication and a summary request line that stays high while any source is pending.

Top module: `irqx_dispatch`

## Requirements
- R1: While reset is asserted, the status word equals its reset values (mask 0, address 0). halted_o, dead_o, busy_o, hard_req_o, mem_we_o, mem_re_o and take_o are all zero.
- R2: Grants follow this rank: program (take_o bit 0), supervisor call (bit 1), queued external (bit 2), clock comparator (bit 3), CPU timer (bit 4). At most one bit of take_o is high, and it is high only in an idle cycle.
- R3: The three external-class sources (bits 2 to 4) are granted only while bit 56 of the current mask is 1. A source that is blocked this way stays pending and is taken once the mask opens.
- R4: A clock-comparator or CPU-timer event pulse sets a pending flag that is cleared when that source is granted. Their interruption codes are 0x1004 and 0x1005. The queued external source uses ext_code_i.
- R5: After a grant, the block performs three write cycles (area +0, +8, +16), then two read cycles (+24, +32), then one load cycle. busy_o is high for exactly these six cycles, and no grant happens while busy_o is high.
- R6: The stored old mask is the current mask with bits 14:13 replaced by cc_i as sampled in the grant cycle.
- R7: For a supervisor call, the stored old address is the current address plus instr_len_i. For all other sources it is the current address.
- R8: The information word holds the interruption code in bits 15:0. Bits 31:16 hold instr_len_i for program and supervisor call, and cpu_num_i ORed with 0x0D00 for the external class. Bits 63:32 hold ext_param_i for the queued external source and zero otherwise.
- R9: Word addresses are prefix_i + class offset + 8*word index. Data byte lane k (bits 8k+7:8k) carries address +k, so a word's most significant byte sits on lane 0. The same order is used on reads.
- R10: After the load cycle, the current mask and address equal the two words read. cc_o equals bits 14:13 of the new mask.
- R11: Loading a mask with bit 49 set sets halted_o. If bits 57, 56 and 50 are also all clear, dead_o is set. Any load without bit 49 clears both.
- R12: hard_req_o is high exactly when any source is pending, whether or not the mask allows it to be taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prefix_i | input | ADDR_W | Base address of the save areas |
| cpu_num_i | input | CPU_NUM_W | CPU number for the external-class address field |
| cc_i | input | 2 | Live condition code |
| instr_len_i | input | ILEN_W | Length of the current instruction in bytes |
| pgm_req_i | input | 1 | Program exception request, held until taken |
| pgm_code_i | input | 16 | Program interruption code |
| svc_req_i | input | 1 | Supervisor-call request, held until taken |
| svc_code_i | input | 16 | Supervisor-call code |
| ext_req_i | input | 1 | Queued external interruption, held until taken |
| ext_code_i | input | 16 | Code of the queued external interruption |
| ext_param_i | input | EXT_PARAM_W | Parameter of the queued external interruption |
| clkcmp_evt_i | input | 1 | Clock-comparator event pulse |
| cputmr_evt_i | input | 1 | CPU-timer event pulse |
| take_o | output | 5 | One-hot grant of the source taken in this cycle |
| hard_req_o | output | 1 | Some source is pending |
| busy_o | output | 1 | Exchange in progress |
| mem_we_o | output | 1 | Save-area write strobe |
| mem_re_o | output | 1 | Save-area read strobe |
| mem_addr_o | output | ADDR_W | Save-area byte address |
| mem_wdata_o | output | 64 | Write data, byte lane k at address +k |
| mem_rdata_i | input | 64 | Read data, valid in the same cycle as mem_re_o |
| psw_mask_o | output | 64 | Current status-word mask |
| psw_addr_o | output | 64 | Current status-word address |
| cc_o | output | 2 | Condition code of the current mask |
| halted_o | output | 1 | Processor is in the wait state |
| dead_o | output | 1 | Wait state with every interruption class masked |

## Verification
The assertions check on every cycle that grants are one-hot, never occur while busy, and never pick an external-class source while bit 56 is clear. They also check that a write cycle directly follows every grant, that a read cycle precedes every load, that a taken clock-comparator flag clears, that an event raises the request line, and that loads update the status word and the halt state. Ranking among simultaneous sources, the content and byte order of each stored word, and the exact interruption codes can only be shown by the bench's scenarios. The same holds for the condition-code insertion, the supervisor-call address offset, a masked source surviving until the mask opens, and the split between the halted and dead-stop outcomes.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

   localparam int WORD_W     = 64;
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int NUM_SRC    = 5;

   // source ranks, lowest index wins
   localparam int SRC_PGM    = 0;
   localparam int SRC_SVC    = 1;
   localparam int SRC_EXTQ   = 2;
   localparam int SRC_CLKCMP = 3;
   localparam int SRC_CPUTMR = 4;
   localparam int FIRST_EXT  = SRC_EXTQ;

   // status-word bit positions
   localparam int CC_LSB   = 13;
   localparam int WAIT_BIT = 49;
   localparam int MCK_BIT  = 50;
   localparam int EXT_BIT  = 56;
   localparam int IO_BIT   = 57;

   localparam logic [15:0] CODE_CLKCMP = 16'h1004;
   localparam logic [15:0] CODE_CPUTMR = 16'h1005;
   localparam logic [15:0] CPU_TAG     = 16'h0D00;

   typedef enum logic [1:0] {
      CLS_EXT = 2'd0,
      CLS_SVC = 2'd1,
      CLS_PGM = 2'd2
   } cls_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_STORE = 2'd1,
      SQ_FETCH = 2'd2,
      SQ_LOAD  = 2'd3
   } sq_e;

   typedef struct packed {
      cls_e              cls;
      logic [WORD_W-1:0] info;
      logic [WORD_W-1:0] old_mask;
      logic [WORD_W-1:0] old_addr;
   } frame_t;

   function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] v);
      logic [WORD_W-1:0] r;
      for (int b = 0; b < WORD_BYTES; b++) begin
         r[8*b +: 8] = v[8*(WORD_BYTES-1-b) +: 8];
      end
      return r;
   endfunction

endpackage

// File: rtl/irqx_arbiter.sv
module irqx_arbiter
   import irqx_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pgm_req_i,
   input  logic               svc_req_i,
   input  logic               extq_req_i,
   input  logic               clkcmp_evt_i,
   input  logic               cputmr_evt_i,
   input  logic               ext_open_i,
   input  logic               can_grant_i,
   output logic [NUM_SRC-1:0] grant_o,
   output logic               hard_req_o
);

   logic               clk_pend_q;
   logic               tmr_pend_q;
   logic [NUM_SRC-1:0] raw;
   logic [NUM_SRC-1:0] elig;
   logic [NUM_SRC-1:0] above;

   assign raw = {tmr_pend_q, clk_pend_q, extq_req_i, svc_req_i, pgm_req_i};
   assign above[0] = 1'b0;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_rank
         if (i < FIRST_EXT) begin : g_core
            assign elig[i] = raw[i];
         end else begin : g_ext
            assign elig[i] = raw[i] & ext_open_i;
         end
         assign grant_o[i] = can_grant_i & elig[i] & ~above[i];
         if (i + 1 < NUM_SRC) begin : g_chain
            assign above[i+1] = above[i] | elig[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_pend_q <= 1'b0;
         tmr_pend_q <= 1'b0;
      end else begin
         clk_pend_q <= (clk_pend_q & ~grant_o[SRC_CLKCMP]) | clkcmp_evt_i;
         tmr_pend_q <= (tmr_pend_q & ~grant_o[SRC_CPUTMR]) | cputmr_evt_i;
      end
   end

   assign hard_req_o = |raw;

   // R4
   clkcmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o[SRC_CLKCMP] && !clkcmp_evt_i) |=> !clk_pend_q);

   // R4
   cputmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o[SRC_CPUTMR] && !cputmr_evt_i) |=> !tmr_pend_q);

   // R12
   evt_raises_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clkcmp_evt_i || cputmr_evt_i) |=> hard_req_o);

endmodule

// File: rtl/irqx_sequencer.sv
module irqx_sequencer
   import irqx_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1,
   parameter int EXT_AREA   = 'h40,
   parameter int SVC_AREA   = 'h80,
   parameter int PGM_AREA   = 'hC0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  frame_t            frame_i,
   input  logic [ADDR_W-1:0] prefix_i,
   input  logic [WORD_W-1:0] mem_rdata_i,
   output logic              busy_o,
   output logic              mem_we_o,
   output logic              mem_re_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [WORD_W-1:0] mem_wdata_o,
   output logic              load_o,
   output logic [WORD_W-1:0] new_mask_o,
   output logic [WORD_W-1:0] new_addr_o
);

   localparam int STORE_WORDS = 3;
   localparam int FETCH_WORDS = 2;
   localparam int TOTAL_WORDS = STORE_WORDS + FETCH_WORDS;
   localparam int IDX_W       = $clog2(TOTAL_WORDS);
   localparam int OFF_SHIFT   = $clog2(WORD_BYTES);
   localparam int AREA_BYTES  = TOTAL_WORDS * WORD_BYTES;

   generate
      if ((EXT_AREA % WORD_BYTES) != 0 || (SVC_AREA % WORD_BYTES) != 0 ||
          (PGM_AREA % WORD_BYTES) != 0) begin : g_bad_align
         $error("save areas must be word aligned");
      end
      if (EXT_AREA + AREA_BYTES > SVC_AREA || SVC_AREA + AREA_BYTES > PGM_AREA) begin : g_bad_gap
         $error("save areas overlap");
      end
   endgenerate

   sq_e               state_q;
   logic [IDX_W-1:0]  idx_q;
   frame_t            frame_q;
   logic [WORD_W-1:0] mask_q;
   logic [WORD_W-1:0] addr_q;
   logic [ADDR_W-1:0] area_off;
   logic [WORD_W-1:0] store_word;
   logic [WORD_W-1:0] read_word;

   always_comb begin
      unique case (frame_q.cls)
         CLS_SVC: area_off = ADDR_W'(SVC_AREA);
         CLS_PGM: area_off = ADDR_W'(PGM_AREA);
         default: area_off = ADDR_W'(EXT_AREA);
      endcase
   end

   always_comb begin
      unique case (idx_q)
         IDX_W'(0): store_word = frame_q.info;
         IDX_W'(1): store_word = frame_q.old_mask;
         default:   store_word = frame_q.old_addr;
      endcase
   end

   generate
      if (BIG_ENDIAN) begin : g_be
         assign mem_wdata_o = swap_bytes(store_word);
         assign read_word   = swap_bytes(mem_rdata_i);
      end else begin : g_le
         assign mem_wdata_o = store_word;
         assign read_word   = mem_rdata_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         idx_q   <= '0;
         frame_q <= '0;
         mask_q  <= '0;
         addr_q  <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (start_i) begin
                  frame_q <= frame_i;
                  idx_q   <= '0;
                  state_q <= SQ_STORE;
               end
            end
            SQ_STORE: begin
               idx_q <= idx_q + 1'b1;
               if (idx_q == IDX_W'(STORE_WORDS - 1)) state_q <= SQ_FETCH;
            end
            SQ_FETCH: begin
               if (idx_q == IDX_W'(STORE_WORDS)) mask_q <= read_word;
               else                              addr_q <= read_word;
               idx_q <= idx_q + 1'b1;
               if (idx_q == IDX_W'(TOTAL_WORDS - 1)) state_q <= SQ_LOAD;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy_o     = (state_q != SQ_IDLE);
   assign mem_we_o   = (state_q == SQ_STORE);
   assign mem_re_o   = (state_q == SQ_FETCH);
   assign load_o     = (state_q == SQ_LOAD);
   assign mem_addr_o = prefix_i + area_off + (ADDR_W'(idx_q) << OFF_SHIFT);
   assign new_mask_o = mask_q;
   assign new_addr_o = addr_q;

   // R5
   store_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> mem_we_o);

   // R5
   fetch_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_o) |-> $past(mem_re_o));

endmodule

// File: rtl/irqx_psw_reg.sv
module irqx_psw_reg
   import irqx_pkg::*;
#(
   parameter logic [WORD_W-1:0] RESET_MASK = '0,
   parameter logic [WORD_W-1:0] RESET_ADDR = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] new_mask_i,
   input  logic [WORD_W-1:0] new_addr_i,
   output logic [WORD_W-1:0] psw_mask_o,
   output logic [WORD_W-1:0] psw_addr_o,
   output logic [1:0]        cc_o,
   output logic              halted_o,
   output logic              dead_o
);

   logic [WORD_W-1:0] mask_q;
   logic [WORD_W-1:0] addr_q;
   logic              halt_q;
   logic              dead_q;
   logic              all_closed;

   assign all_closed = ~(new_mask_i[IO_BIT] | new_mask_i[EXT_BIT] | new_mask_i[MCK_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= RESET_MASK;
         addr_q <= RESET_ADDR;
         halt_q <= 1'b0;
         dead_q <= 1'b0;
      end else if (load_i) begin
         mask_q <= new_mask_i;
         addr_q <= new_addr_i;
         halt_q <= new_mask_i[WAIT_BIT];
         dead_q <= new_mask_i[WAIT_BIT] & all_closed;
      end
   end

   assign psw_mask_o = mask_q;
   assign psw_addr_o = addr_q;
   assign cc_o       = mask_q[CC_LSB +: 2];
   assign halted_o   = halt_q;
   assign dead_o     = dead_q;

   // R11
   wait_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && new_mask_i[WAIT_BIT]) |=> halted_o);

   // R11
   dead_implies_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dead_o |-> halted_o);

   // R10
   load_updates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (psw_addr_o == $past(new_addr_i) && psw_mask_o == $past(new_mask_i)));

endmodule

// File: rtl/irqx_dispatch.sv
module irqx_dispatch
   import irqx_pkg::*;
#(
   parameter int                ADDR_W      = 32,
   parameter int                CPU_NUM_W   = 8,
   parameter int                ILEN_W      = 4,
   parameter int                EXT_PARAM_W = 32,
   parameter bit                BIG_ENDIAN  = 1'b1,
   parameter int                EXT_AREA    = 'h40,
   parameter int                SVC_AREA    = 'h80,
   parameter int                PGM_AREA    = 'hC0,
   parameter logic [WORD_W-1:0] RESET_MASK  = '0,
   parameter logic [WORD_W-1:0] RESET_ADDR  = '0
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      prefix_i,
   input  logic [CPU_NUM_W-1:0]   cpu_num_i,
   input  logic [1:0]             cc_i,
   input  logic [ILEN_W-1:0]      instr_len_i,
   input  logic                   pgm_req_i,
   input  logic [15:0]            pgm_code_i,
   input  logic                   svc_req_i,
   input  logic [15:0]            svc_code_i,
   input  logic                   ext_req_i,
   input  logic [15:0]            ext_code_i,
   input  logic [EXT_PARAM_W-1:0] ext_param_i,
   input  logic                   clkcmp_evt_i,
   input  logic                   cputmr_evt_i,
   output logic [NUM_SRC-1:0]     take_o,
   output logic                   hard_req_o,
   output logic                   busy_o,
   output logic                   mem_we_o,
   output logic                   mem_re_o,
   output logic [ADDR_W-1:0]      mem_addr_o,
   output logic [WORD_W-1:0]      mem_wdata_o,
   input  logic [WORD_W-1:0]      mem_rdata_i,
   output logic [WORD_W-1:0]      psw_mask_o,
   output logic [WORD_W-1:0]      psw_addr_o,
   output logic [1:0]             cc_o,
   output logic                   halted_o,
   output logic                   dead_o
);

   generate
      if (ILEN_W > 16) begin : g_bad_ilen
         $error("instruction length field is limited to 16 bits");
      end
      if (CPU_NUM_W > 16) begin : g_bad_cpu
         $error("cpu number field is limited to 16 bits");
      end
      if (EXT_PARAM_W > 32) begin : g_bad_param
         $error("external parameter is limited to 32 bits");
      end
      if (ADDR_W < 9 || ADDR_W > WORD_W) begin : g_bad_addr
         $error("address width out of range");
      end
   endgenerate

   logic              load;
   logic [WORD_W-1:0] new_mask;
   logic [WORD_W-1:0] new_addr;
   frame_t            frame;
   logic [15:0]       code;
   logic [15:0]       aux_field;
   logic [31:0]       param_field;
   logic [WORD_W-1:0] cc_mask;

   irqx_arbiter u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .pgm_req_i    (pgm_req_i),
      .svc_req_i    (svc_req_i),
      .extq_req_i   (ext_req_i),
      .clkcmp_evt_i (clkcmp_evt_i),
      .cputmr_evt_i (cputmr_evt_i),
      .ext_open_i   (psw_mask_o[EXT_BIT]),
      .can_grant_i  (!busy_o),
      .grant_o      (take_o),
      .hard_req_o   (hard_req_o)
   );

   always_comb begin
      code        = '0;
      aux_field   = 16'(cpu_num_i) | CPU_TAG;
      param_field = '0;
      frame.cls   = CLS_EXT;
      if (take_o[SRC_PGM]) begin
         code      = pgm_code_i;
         aux_field = 16'(instr_len_i);
         frame.cls = CLS_PGM;
      end else if (take_o[SRC_SVC]) begin
         code      = svc_code_i;
         aux_field = 16'(instr_len_i);
         frame.cls = CLS_SVC;
      end else if (take_o[SRC_EXTQ]) begin
         code        = ext_code_i;
         param_field = 32'(ext_param_i);
      end else if (take_o[SRC_CLKCMP]) begin
         code = CODE_CLKCMP;
      end else begin
         code = CODE_CPUTMR;
      end
   end

   always_comb begin
      cc_mask                = psw_mask_o;
      cc_mask[CC_LSB +: 2]   = cc_i;
   end

   assign frame.info     = {param_field, aux_field, code};
   assign frame.old_mask = cc_mask;
   assign frame.old_addr = psw_addr_o +
                           (take_o[SRC_SVC] ? WORD_W'(instr_len_i) : {WORD_W{1'b0}});

   irqx_sequencer #(
      .ADDR_W     (ADDR_W),
      .BIG_ENDIAN (BIG_ENDIAN),
      .EXT_AREA   (EXT_AREA),
      .SVC_AREA   (SVC_AREA),
      .PGM_AREA   (PGM_AREA)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (|take_o),
      .frame_i     (frame),
      .prefix_i    (prefix_i),
      .mem_rdata_i (mem_rdata_i),
      .busy_o      (busy_o),
      .mem_we_o    (mem_we_o),
      .mem_re_o    (mem_re_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .load_o      (load),
      .new_mask_o  (new_mask),
      .new_addr_o  (new_addr)
   );

   irqx_psw_reg #(
      .RESET_MASK (RESET_MASK),
      .RESET_ADDR (RESET_ADDR)
   ) u_psw (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .new_mask_i (new_mask),
      .new_addr_i (new_addr),
      .psw_mask_o (psw_mask_o),
      .psw_addr_o (psw_addr_o),
      .cc_o       (cc_o),
      .halted_o   (halted_o),
      .dead_o     (dead_o)
   );

   // R2
   take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take_o));

   // R5
   no_take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|take_o) |-> !busy_o);

   // R3
   ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|take_o[NUM_SRC-1:FIRST_EXT]) |-> psw_mask_o[EXT_BIT]);

   // R5
   busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|take_o) |=> busy_o);

endmodule

// File: tb/irqx_dispatch_tb.sv
`timescale 1ns/1ps
module irqx_dispatch_tb;

   localparam logic [31:0] PREFIX = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] prefix = PREFIX;
   logic [7:0]  cpu_num = 8'h05;
   logic [1:0]  cc = 2'd0;
   logic [3:0]  ilen = 4'd4;
   logic        pgm_req = 1'b0, svc_req = 1'b0, ext_req = 1'b0;
   logic [15:0] pgm_code = 16'h0011, svc_code = 16'h0021, ext_code = 16'h2401;
   logic [31:0] ext_param = 32'hCAFE_0001;
   logic        clkcmp_evt = 1'b0, cputmr_evt = 1'b0;
   logic [4:0]  take;
   logic        hard_req, busy, mem_we, mem_re, halted, dead;
   logic [31:0] mem_addr;
   logic [63:0] mem_wdata, mem_rdata, psw_mask, psw_addr;
   logic [1:0]  cc_out;

   logic [63:0] mem_arr [0:63];

   always #2 clk = ~clk;

   irqx_dispatch u_dut (
      .clk(clk), .rst_n(rst_n), .prefix_i(prefix), .cpu_num_i(cpu_num), .cc_i(cc),
      .instr_len_i(ilen), .pgm_req_i(pgm_req), .pgm_code_i(pgm_code),
      .svc_req_i(svc_req), .svc_code_i(svc_code), .ext_req_i(ext_req),
      .ext_code_i(ext_code), .ext_param_i(ext_param), .clkcmp_evt_i(clkcmp_evt),
      .cputmr_evt_i(cputmr_evt), .take_o(take), .hard_req_o(hard_req), .busy_o(busy),
      .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .psw_mask_o(psw_mask),
      .psw_addr_o(psw_addr), .cc_o(cc_out), .halted_o(halted), .dead_o(dead)
   );

   assign mem_rdata = mem_arr[mem_addr[8:3]];
   always @(posedge clk) if (mem_we) mem_arr[mem_addr[8:3]] <= mem_wdata;

   int checks = 0;
   int errors = 0;
   bit chk_on = 0;
   bit done = 0;

   function automatic logic [63:0] bswap(input logic [63:0] v);
      logic [63:0] r;
      for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
      return r;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic put(input logic [31:0] a, input logic [63:0] v);
      mem_arr[a[8:3]] = bswap(v);
   endtask

   // behavioural reference model
   int          m_ph = 0;
   int          m_cls = 0;
   int          m_last = -1;
   logic [63:0] m_w [0:4];
   logic        m_tod = 0, m_tmr = 0, m_halt = 0, m_dead = 0;
   logic [63:0] m_mask = '0, m_addr = '0;

   function automatic int exp_take();
      if (m_ph != 0) return -1;
      if (pgm_req) return 0;
      if (svc_req) return 1;
      if (!m_mask[56]) return -1;
      if (ext_req) return 2;
      if (m_tod) return 3;
      if (m_tmr) return 4;
      return -1;
   endfunction

   function automatic logic [31:0] area_of(input int c);
      return prefix + (c == 2 ? 32'hC0 : c == 1 ? 32'h80 : 32'h40);
   endfunction

   always @(posedge clk) begin
      int t;
      logic [15:0] code;
      logic [31:0] a;
      if (!rst_n) begin
         m_ph = 0; m_tod = 0; m_tmr = 0; m_halt = 0; m_dead = 0;
         m_mask = '0; m_addr = '0; m_last = -1;
      end else begin
         t = exp_take();
         if (m_ph == 0) begin
            if (t >= 0) begin
               code = t == 0 ? pgm_code : t == 1 ? svc_code : t == 2 ? ext_code :
                      t == 3 ? 16'h1004 : 16'h1005;
               m_w[0] = {(t == 2 ? ext_param : 32'h0),
                         (t <= 1 ? 16'(ilen) : (16'(cpu_num) | 16'h0D00)), code};
               m_w[1] = {m_mask[63:15], cc, m_mask[12:0]};
               m_w[2] = (t == 1) ? m_addr + 64'(ilen) : m_addr;
               m_cls  = t == 0 ? 2 : t == 1 ? 1 : 0;
               m_ph   = 1;
            end
         end else if (m_ph <= 3) begin
            m_ph++;
         end else if (m_ph <= 5) begin
            a = area_of(m_cls) + 32'((m_ph - 1) * 8);
            m_w[m_ph-1] = bswap(mem_arr[a[8:3]]);
            m_ph++;
         end else begin
            m_mask = m_w[3];
            m_addr = m_w[4];
            m_halt = m_w[3][49];
            m_dead = m_w[3][49] & ~(m_w[3][57] | m_w[3][56] | m_w[3][50]);
            m_ph   = 0;
         end
         if (t == 3) m_tod = 0;
         if (t == 4) m_tmr = 0;
         if (clkcmp_evt) m_tod = 1;
         if (cputmr_evt) m_tmr = 1;
         m_last = t;
      end
   end

   // requesters drop a level request once it has been taken
   always @(negedge clk) begin
      case (m_last)
         0: pgm_req = 1'b0;
         1: svc_req = 1'b0;
         2: ext_req = 1'b0;
         default: ;
      endcase
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      int t;
      logic [31:0] a;
      #1;
      if (chk_on && !done) begin
         t = exp_take();
         check("R2 R3 take", 64'(take), t >= 0 ? 64'(5'b1 << t) : 64'h0);
         check("R5 busy", 64'(busy), 64'(m_ph != 0));
         check("R5 write strobe", 64'(mem_we), 64'(m_ph >= 1 && m_ph <= 3));
         check("R5 read strobe", 64'(mem_re), 64'(m_ph >= 4 && m_ph <= 5));
         if (m_ph >= 1 && m_ph <= 5) begin
            a = area_of(m_cls) + 32'((m_ph - 1) * 8);
            check("R9 address", 64'(mem_addr), 64'(a));
         end
         if (m_ph == 1) check("R8 info word R4 code", mem_wdata, bswap(m_w[0]));
         if (m_ph == 2) check("R6 old mask", mem_wdata, bswap(m_w[1]));
         if (m_ph == 3) check("R7 old address", mem_wdata, bswap(m_w[2]));
         check("R12 hard_req", 64'(hard_req),
               64'(pgm_req | svc_req | ext_req | m_tod | m_tmr));
         check("R10 mask", psw_mask, m_mask);
         check("R10 address", psw_addr, m_addr);
         check("R10 cc", 64'(cc_out), 64'(m_mask[14:13]));
         check("R11 halted", 64'(halted), 64'(m_halt));
         check("R11 dead", 64'(dead), 64'(m_dead));
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_events(input logic tod, input logic tmr);
      @(negedge clk);
      clkcmp_evt = tod;
      cputmr_evt = tmr;
      @(negedge clk);
      clkcmp_evt = 1'b0;
      cputmr_evt = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem_arr[i] = '0;
      put(PREFIX + 32'h80 + 24, 64'h0100_0000_0000_2000);
      put(PREFIX + 32'h80 + 32, 64'h0000_0000_0000_2000);
      put(PREFIX + 32'h40 + 24, 64'h0100_0000_0000_4000);
      put(PREFIX + 32'h40 + 32, 64'h0000_0000_0000_3000);
      put(PREFIX + 32'hC0 + 24, 64'h0100_0000_0000_0000);
      put(PREFIX + 32'hC0 + 32, 64'h0000_0000_0000_4000);

      cycles(3);
      // R1 reset state
      check("R1 reset mask", psw_mask, 64'h0);
      check("R1 reset address", psw_addr, 64'h0);
      check("R1 reset busy", 64'(busy), 64'h0);
      check("R1 reset strobes", 64'({mem_we, mem_re}), 64'h0);
      check("R1 reset halted dead", 64'({halted, dead}), 64'h0);
      check("R1 reset take", 64'(take), 64'h0);
      check("R1 reset hard_req", 64'(hard_req), 64'h0);
      rst_n = 1'b1;
      chk_on = 1'b1;
      cycles(2);

      // R3: clock-comparator event while the external mask is closed
      pulse_events(1'b1, 1'b0);
      cycles(5);

      // R7: supervisor call opens the mask; pending event then taken (R3, R4)
      cc = 2'd2;
      ilen = 4'd4;
      svc_req = 1'b1;
      cycles(25);

      // R2: queued external, clock comparator and timer together
      cc = 2'd1;
      ext_req = 1'b1;
      pulse_events(1'b1, 1'b1);
      cycles(30);

      // R2: program and supervisor call together
      cc = 2'd3;
      ilen = 4'd6;
      pgm_req = 1'b1;
      svc_req = 1'b1;
      cycles(25);

      // R11: wait state with the external mask open -> halted only
      put(PREFIX + 32'h40 + 24, 64'h0102_0000_0000_0000);
      ext_req = 1'b1;
      cycles(12);

      // R11: wait state with every mask closed -> dead stop
      put(PREFIX + 32'hC0 + 24, 64'h0002_0000_0000_2000);
      pgm_req = 1'b1;
      cycles(12);

      // R12: nothing left pending
      check("R12 idle request line", 64'(hard_req), 64'h0);
      check("R11 final dead", 64'(dead), 64'h1);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule